// File: doc/BRIEF.md
# Tagged Load Value Replay Queue

This block sits in the trailing core of a redundant-execution pair. The leading core sends the value of every load it retires over a dedicated link, in retirement order. Each arriving value goes into the next slot of a circular store, and that slot number becomes the value's tag. No tag travels on the link. The trailing core's decoder takes tags from an independent in-order counter. Because both sides count loads in the same order, the Nth decoded load is paired with the Nth arriving value.

The execute side reads by tag and may do so in any order. A read whose slot already holds a value is answered directly. A read whose value has not yet arrived is parked in a small miss-holding table and answered as soon as the matching value lands. Slots are released in order as loads retire in the trailing core. The block raises `full` so that the leading core stops retiring loads. Tags stay unique only while the depth exceeds the largest number of loads in flight.

Top module: `replay_ldq`

## Requirements
- R1: After reset `rsp_valid` is 0, `full` is 0, `dec_tag` is 0 and `rd_ready` is 1.
- R2: A value offered on `link_valid`/`link_data` while `full` is low is written into the slot at the write pointer, which starts at 0 and wraps modulo DEPTH. A value offered while `full` is high is dropped and changes no slot.
- R3: `full` is high exactly when DEPTH values are held, meaning written and not yet released. It falls in the cycle after a release from a full queue.
- R4: `dec_tag` starts at 0 and advances by one, modulo DEPTH, after each cycle with `dec_take` high. Otherwise it holds.
- R5: A read accepted (`rd_req` and `rd_ready`) to a filled slot, in a cycle where no parked read is answered, gives `rsp_valid` with that tag and the slot's data one cycle later.
- R6: A read accepted to an empty slot is parked. It is answered one cycle after the edge that writes its slot, with the data just written.
- R7: Each cycle at most one parked read is answered: the lowest-index table entry whose slot is filled or is being written. A read accepted in a cycle where a parked read is answered is parked, even if its slot is filled. A new read takes the lowest free table entry.
- R8: `rd_ready` is low while all PARK_N table entries are occupied. A read offered while `rd_ready` is low is dropped and never answered.
- R9: `ret_req` releases the oldest held slot and advances the release pointer. When the oldest slot holds no value, `ret_req` is ignored.
- R10: A read that targets the slot written in the same cycle is treated as a miss. It is answered one cycle later than a hit would be.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_valid | input | 1 | Load value offered by the leading core |
| link_data | input | DATA_W | Load value |
| full | output | 1 | Store holds DEPTH values; producer must hold off |
| dec_take | input | 1 | Decoder takes the current tag |
| dec_tag | output | TAG_W | Tag for the next decoded load |
| rd_req | input | 1 | Execute-side read request |
| rd_tag | input | TAG_W | Tag (slot) to read |
| rd_ready | output | 1 | A miss-holding entry is free; reads accepted |
| rsp_valid | output | 1 | Read response valid |
| rsp_tag | output | TAG_W | Tag of the answered read |
| rsp_data | output | DATA_W | Load value for the answered read |
| ret_req | input | 1 | Oldest load retired; release its slot |

## Verification
Responses come from a single output register. A hit therefore appears one cycle after it is accepted, and a parked read appears one cycle after the edge that stores its value. A read that collides with the write of its own slot, or with an answer from the table, takes a further cycle. `full` and `dec_tag` update at the edge after the input that moves them, and `rd_ready` follows the table occupancy from that same edge. The bench applies inputs on the falling edge. A behavioural model with plain arrays updates on the rising edge, and every output is compared at the next falling edge, so each expectation is sampled exactly one edge after its cause. Directed sequences confirm the cycle of the parked answer, the same-cycle collision and the priority order with literal tags and data.

// File: rtl/rlq_pkg.sv
package rlq_pkg;

   localparam int unsigned RLQ_DEF_DEPTH  = 256;
   localparam int unsigned RLQ_DEF_DATA_W = 32;
   localparam int unsigned RLQ_DEF_PARK_N = 4;

   // source of the value loaded into the response register this cycle
   typedef enum logic [1:0] {
      RSP_IDLE      = 2'd0,
      RSP_HIT       = 2'd1,
      RSP_PARK_MEM  = 2'd2,
      RSP_PARK_LINK = 2'd3
   } rsp_src_e;

endpackage

// File: rtl/rlq_slot_ring.sv
module rlq_slot_ring #(
   parameter  int unsigned DEPTH  = 256,
   parameter  int unsigned DATA_W = 32,
   localparam int unsigned TAG_W  = $clog2(DEPTH),
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              free_req,
   input  logic [TAG_W-1:0]  hit_addr,
   input  logic [TAG_W-1:0]  park_addr,
   output logic              full,
   output logic              wr_go,
   output logic              free_go,
   output logic [TAG_W-1:0]  wr_slot,
   output logic [DEPTH-1:0]  filled,
   output logic [DATA_W-1:0] hit_data,
   output logic [DATA_W-1:0] park_data
);

   logic [TAG_W-1:0]  wr_q;
   logic [TAG_W-1:0]  hd_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DEPTH-1:0]  fill_q;
   logic [DATA_W-1:0] mem_q [DEPTH];

   assign full      = (cnt_q == CNT_W'(DEPTH));
   assign wr_go     = wr_req && !full;
   assign free_go   = free_req && fill_q[hd_q];
   assign wr_slot   = wr_q;
   assign filled    = fill_q;
   assign hit_data  = mem_q[hit_addr];
   assign park_data = mem_q[park_addr];

   always_ff @(posedge clk) begin
      if (wr_go) mem_q[wr_q] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q   <= '0;
         hd_q   <= '0;
         fill_q <= '0;
      end else begin
         if (wr_go) begin
            wr_q         <= wr_q + 1'b1;
            fill_q[wr_q] <= 1'b1;
         end
         if (free_go) begin
            hd_q         <= hd_q + 1'b1;
            fill_q[hd_q] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case ({wr_go, free_go})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

endmodule

// File: rtl/rlq_tag_issue.sv
module rlq_tag_issue #(
   parameter  int unsigned DEPTH = 256,
   localparam int unsigned TAG_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   output logic [TAG_W-1:0] tag
);

   logic [TAG_W-1:0] next_q;

   assign tag = next_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    next_q <= '0;
      else if (take) next_q <= next_q + 1'b1;
   end

endmodule

// File: rtl/rlq_miss_park.sv
module rlq_miss_park #(
   parameter  int unsigned DEPTH  = 256,
   parameter  int unsigned PARK_N = 4,
   localparam int unsigned TAG_W  = $clog2(DEPTH),
   localparam int unsigned SEL_W  = (PARK_N > 1) ? $clog2(PARK_N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] filled,
   input  logic             wr_go,
   input  logic [TAG_W-1:0] wr_slot,
   input  logic             park_req,
   input  logic [TAG_W-1:0] park_tag,
   output logic             ready,
   output logic             serve,
   output logic [TAG_W-1:0] serve_tag,
   output logic             serve_link
);

   logic [PARK_N-1:0] busy_q;
   logic [TAG_W-1:0]  tag_q [PARK_N];
   logic [PARK_N-1:0] elig;
   logic [SEL_W-1:0]  srv_sel;
   logic [SEL_W-1:0]  free_sel;

   // an entry may be answered when its slot holds data or is written now
   for (genvar e = 0; e < PARK_N; e++) begin : g_elig
      assign elig[e] = busy_q[e] &&
                       (filled[tag_q[e]] || (wr_go && (tag_q[e] == wr_slot)));
   end

   if (PARK_N == 1) begin : g_single
      assign srv_sel  = '0;
      assign free_sel = '0;
   end else begin : g_multi
      always_comb begin
         srv_sel  = '0;
         free_sel = '0;
         for (int i = PARK_N - 1; i >= 0; i--) begin
            if (elig[i])    srv_sel  = SEL_W'(i);
            if (!busy_q[i]) free_sel = SEL_W'(i);
         end
      end
   end

   assign ready      = !(&busy_q);
   assign serve      = |elig;
   assign serve_tag  = tag_q[srv_sel];
   assign serve_link = !filled[tag_q[srv_sel]];

   for (genvar e = 0; e < PARK_N; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_q[e] <= 1'b0;
            tag_q[e]  <= '0;
         end else if (park_req && ready && (free_sel == SEL_W'(e))) begin
            busy_q[e] <= 1'b1;
            tag_q[e]  <= park_tag;
         end else if (serve && (srv_sel == SEL_W'(e))) begin
            busy_q[e] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/replay_ldq.sv
module replay_ldq
   import rlq_pkg::*;
#(
   parameter  int unsigned DEPTH  = RLQ_DEF_DEPTH,
   parameter  int unsigned DATA_W = RLQ_DEF_DATA_W,
   parameter  int unsigned PARK_N = RLQ_DEF_PARK_N,
   localparam int unsigned TAG_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_valid,
   input  logic [DATA_W-1:0] link_data,
   output logic              full,
   input  logic              dec_take,
   output logic [TAG_W-1:0]  dec_tag,
   input  logic              rd_req,
   input  logic [TAG_W-1:0]  rd_tag,
   output logic              rd_ready,
   output logic              rsp_valid,
   output logic [TAG_W-1:0]  rsp_tag,
   output logic [DATA_W-1:0] rsp_data,
   input  logic              ret_req
);

   if (DEPTH < 2 || (1 << TAG_W) != DEPTH) begin : g_bad_depth
      $error("replay_ldq: DEPTH must be a power of two of at least 2");
   end
   if (PARK_N < 1 || PARK_N > 16) begin : g_bad_park
      $error("replay_ldq: PARK_N must lie in 1..16");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("replay_ldq: DATA_W must be at least 1");
   end

   logic              wr_go;
   logic              ret_go;
   logic [TAG_W-1:0]  wr_slot;
   logic [DEPTH-1:0]  filled;
   logic [DATA_W-1:0] hit_data;
   logic [DATA_W-1:0] park_data;
   logic              serve;
   logic [TAG_W-1:0]  serve_tag;
   logic              serve_link;
   logic              rd_acc;
   logic              rd_hit;
   logic              rd_park;
   rsp_src_e          src;

   rlq_slot_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_req    (link_valid),
      .wr_data   (link_data),
      .free_req  (ret_req),
      .hit_addr  (rd_tag),
      .park_addr (serve_tag),
      .full      (full),
      .wr_go     (wr_go),
      .free_go   (ret_go),
      .wr_slot   (wr_slot),
      .filled    (filled),
      .hit_data  (hit_data),
      .park_data (park_data)
   );

   rlq_tag_issue #(.DEPTH(DEPTH)) u_issue (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (dec_take),
      .tag   (dec_tag)
   );

   rlq_miss_park #(.DEPTH(DEPTH), .PARK_N(PARK_N)) u_park (
      .clk        (clk),
      .rst_n      (rst_n),
      .filled     (filled),
      .wr_go      (wr_go),
      .wr_slot    (wr_slot),
      .park_req   (rd_park),
      .park_tag   (rd_tag),
      .ready      (rd_ready),
      .serve      (serve),
      .serve_tag  (serve_tag),
      .serve_link (serve_link)
   );

   // a parked answer owns the response register; a new read then parks
   assign rd_acc  = rd_req && rd_ready;
   assign rd_hit  = rd_acc && filled[rd_tag] && !serve;
   assign rd_park = rd_acc && !rd_hit;

   always_comb begin
      if (serve)       src = serve_link ? RSP_PARK_LINK : RSP_PARK_MEM;
      else if (rd_hit) src = RSP_HIT;
      else             src = RSP_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_tag   <= '0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= (src != RSP_IDLE);
         unique case (src)
            RSP_HIT: begin
               rsp_tag  <= rd_tag;
               rsp_data <= hit_data;
            end
            RSP_PARK_MEM: begin
               rsp_tag  <= serve_tag;
               rsp_data <= park_data;
            end
            RSP_PARK_LINK: begin
               rsp_tag  <= serve_tag;
               rsp_data <= link_data;
            end
            default: begin
               rsp_tag  <= rsp_tag;
               rsp_data <= rsp_data;
            end
         endcase
      end
   end

endmodule

// File: rtl/replay_ldq_chk.sv
module replay_ldq_chk #(
   parameter  int unsigned DEPTH  = 256,
   parameter  int unsigned PARK_N = 4,
   localparam int unsigned TAG_W  = $clog2(DEPTH),
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             link_valid,
   input logic             full,
   input logic             ret_go,
   input logic             dec_take,
   input logic [TAG_W-1:0] dec_tag,
   input logic             rd_req,
   input logic             rd_ready,
   input logic             rsp_valid
);

   logic [CNT_W-1:0] held_q;
   logic [7:0]       owed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= '0;
         owed_q <= '0;
      end else begin
         held_q <= held_q + CNT_W'(link_valid && !full) - CNT_W'(ret_go);
         owed_q <= owed_q + 8'(rd_req && rd_ready) - 8'(rsp_valid);
      end
   end

   // R3: full tracks an independent count of held values
   a_r3_full_count : assert property (@(posedge clk) disable iff (!rst_n)
      full == (held_q == CNT_W'(DEPTH)));

   // R9: a release never happens with nothing held
   a_r9_release_held : assert property (@(posedge clk) disable iff (!rst_n)
      ret_go |-> (held_q != '0));

   // R4: tag counter steps by one on a take
   a_r4_tag_step : assert property (@(posedge clk) disable iff (!rst_n)
      dec_take |=> (dec_tag == TAG_W'($past(dec_tag) + 1'b1)));

   // R4: tag counter holds otherwise
   a_r4_tag_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !dec_take |=> $stable(dec_tag));

   // R8: reads are refused only when every table entry is owed an answer
   a_r8_ready_gate : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_ready |-> (owed_q >= 8'(PARK_N)));

   // R6: every response answers an earlier accepted read
   a_r6_rsp_owed : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (owed_q != 8'd0));

endmodule

bind replay_ldq replay_ldq_chk #(.DEPTH(DEPTH), .PARK_N(PARK_N)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .link_valid (link_valid),
   .full       (full),
   .ret_go     (ret_go),
   .dec_take   (dec_take),
   .dec_tag    (dec_tag),
   .rd_req     (rd_req),
   .rd_ready   (rd_ready),
   .rsp_valid  (rsp_valid)
);

// File: tb/test_replay_ldq.sv
module test_replay_ldq;

   localparam int D  = 16;
   localparam int P  = 4;
   localparam int TW = $clog2(D);
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          link_valid = 1'b0;
   logic [DW-1:0] link_data = '0;
   logic          full;
   logic          dec_take = 1'b0;
   logic [TW-1:0] dec_tag;
   logic          rd_req = 1'b0;
   logic [TW-1:0] rd_tag = '0;
   logic          rd_ready;
   logic          rsp_valid;
   logic [TW-1:0] rsp_tag;
   logic [DW-1:0] rsp_data;
   logic          ret_req = 1'b0;

   int n_chk = 0;
   int n_err = 0;
   bit cmp_en = 1'b0;
   bit done = 1'b0;
   int seq = 0;

   always #4 clk = ~clk;

   replay_ldq #(.DEPTH(D), .DATA_W(DW), .PARK_N(P)) i_replay_ldq (
      .clk(clk), .rst_n(rst_n), .link_valid(link_valid), .link_data(link_data),
      .full(full), .dec_take(dec_take), .dec_tag(dec_tag), .rd_req(rd_req),
      .rd_tag(rd_tag), .rd_ready(rd_ready), .rsp_valid(rsp_valid),
      .rsp_tag(rsp_tag), .rsp_data(rsp_data), .ret_req(ret_req)
   );

   // behavioural reference
   int m_mem [D];
   bit m_v [D];
   int m_wp, m_hp, m_cnt, m_tag;
   bit pv [P];
   int pt [P];
   bit e_v;
   int e_tag;
   int e_data;
   int n_alloc, n_ret, n_push;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < D; i++) m_v[i] = 0;
         for (int i = 0; i < P; i++) pv[i] = 0;
         m_wp = 0; m_hp = 0; m_cnt = 0; m_tag = 0; e_v = 0;
         n_alloc = 0; n_ret = 0; n_push = 0;
      end else begin
         bit pf, rf, acc, hit;
         int sel, fr;
         pf = link_valid && (m_cnt != D);
         rf = ret_req && m_v[m_hp];
         sel = -1; fr = -1;
         for (int i = 0; i < P; i++) begin
            if (sel < 0 && pv[i] && (m_v[pt[i]] || (pf && pt[i] == m_wp))) sel = i;
            if (fr < 0 && !pv[i]) fr = i;
         end
         acc = rd_req && (fr >= 0);
         hit = acc && m_v[int'(rd_tag)] && (sel < 0);
         e_v = 0;
         if (sel >= 0) begin
            e_v = 1; e_tag = pt[sel];
            e_data = m_v[pt[sel]] ? m_mem[pt[sel]] : int'(link_data);
            pv[sel] = 0;
         end else if (hit) begin
            e_v = 1; e_tag = int'(rd_tag); e_data = m_mem[int'(rd_tag)];
         end
         if (acc && !hit) begin pv[fr] = 1; pt[fr] = int'(rd_tag); end
         if (rf) begin m_v[m_hp] = 0; m_hp = (m_hp + 1) % D; n_ret++; end
         if (pf) begin
            m_mem[m_wp] = int'(link_data); m_v[m_wp] = 1;
            m_wp = (m_wp + 1) % D; n_push++;
         end
         m_cnt = m_cnt + int'(pf) - int'(rf);
         if (dec_take) begin m_tag = (m_tag + 1) % D; n_alloc++; end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit any_free();
      bit f = 0;
      for (int i = 0; i < P; i++) if (!pv[i]) f = 1;
      return f;
   endfunction

   // per-cycle comparison one edge after each cause
   always @(negedge clk) begin
      if (cmp_en && rst_n) begin
         chk(rsp_valid == e_v, "R5/R6 rsp_valid", int'(rsp_valid), int'(e_v));
         if (e_v && rsp_valid) begin
            chk(int'(rsp_tag) == e_tag, "R7 rsp_tag", int'(rsp_tag), e_tag);
            chk(int'(rsp_data) == e_data, "R6 rsp_data", int'(rsp_data), e_data);
         end
         chk(full == (m_cnt == D), "R3 full", int'(full), int'(m_cnt == D));
         chk(int'(dec_tag) == m_tag, "R4 dec_tag", int'(dec_tag), m_tag);
         chk(rd_ready == any_free(), "R8 rd_ready", int'(rd_ready), int'(any_free()));
      end
   end

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      link_valid = 0; dec_take = 0; rd_req = 0; ret_req = 0;
   endtask

   task automatic push1();
      link_valid = 1; link_data = 32'hA000_0000 + DW'(seq); seq++;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      chk(!rsp_valid && !full && dec_tag == 0 && rd_ready, "R1 reset state",
          {rsp_valid, full, rd_ready}, 3'b001);
      cmp_en = 1;

      // R4: hand out eight tags
      dec_take = 1;
      for (int k = 0; k < 8; k++) tick();
      idle();
      chk(dec_tag == 8, "R4 tag count", int'(dec_tag), 8);

      // R8: fill the miss table with reads of empty slots
      rd_req = 1;
      rd_tag = 1; tick();
      rd_tag = 2; tick();
      rd_tag = 3; tick();
      rd_tag = 0; tick();
      chk(!rd_ready, "R8 table full", int'(rd_ready), 0);
      rd_tag = 4; tick();
      idle();

      // R6: values arrive for slots 0..7
      for (int k = 0; k < 8; k++) begin
         push1(); tick();
         if (k == 0) chk(rsp_valid && rsp_tag == 0 && rsp_data == 32'hA000_0000,
                         "R6 parked answer", int'(rsp_tag), 0);
         if (k == 4) chk(!rsp_valid, "R8 dropped read", int'(rsp_valid), 0);
      end
      idle();

      // R7: priority among parked reads
      dec_take = 1;
      for (int k = 0; k < 4; k++) tick();
      idle();
      rd_req = 1;
      rd_tag = 9; tick();
      rd_tag = 9; tick();
      rd_tag = 8; tick();
      idle();
      push1(); tick();
      chk(rsp_valid && rsp_tag == 8, "R7 first answer", int'(rsp_tag), 8);
      push1(); tick();
      chk(rsp_valid && rsp_tag == 9, "R7 lowest entry", int'(rsp_tag), 9);
      idle();
      rd_req = 1; rd_tag = 3; tick();
      rd_req = 0;
      chk(rsp_valid && rsp_tag == 9 && rsp_data == 32'hA000_0009,
          "R7 second parked", int'(rsp_data), 32'hA000_0009);
      tick();
      chk(rsp_valid && rsp_tag == 3, "R7 read parked behind answer", int'(rsp_tag), 3);

      // R10: read meets the write of its own slot
      push1(); rd_req = 1; rd_tag = 10; tick();
      idle();
      chk(!rsp_valid, "R10 no hit on write cycle", int'(rsp_valid), 0);
      tick();
      chk(rsp_valid && rsp_tag == 10 && rsp_data == 32'hA000_000A,
          "R10 answered next", int'(rsp_data), 32'hA000_000A);

      // R5: plain hit
      rd_req = 1; rd_tag = 5; tick();
      rd_req = 0;
      chk(rsp_valid && rsp_tag == 5 && rsp_data == 32'hA000_0005,
          "R5 hit", int'(rsp_data), 32'hA000_0005);

      // R3 and R2: fill, overflow, release
      for (int k = 0; k < 5; k++) begin push1(); tick(); end
      chk(full, "R3 full at depth", int'(full), 1);
      push1(); tick();
      idle();
      ret_req = 1; tick();
      ret_req = 0;
      chk(!full, "R3 full drops", int'(full), 0);
      push1(); tick();
      idle();
      dec_take = 1;
      for (int k = 0; k < 4; k++) tick();
      idle();
      rd_req = 1; rd_tag = 0; tick();
      rd_req = 0;
      chk(rsp_valid && rsp_data == 32'hA000_0011, "R2 wrap, dropped value absent",
          int'(rsp_data), 32'hA000_0011);

      // R9: drain, spurious release, refill
      ret_req = 1;
      for (int k = 0; k < 16; k++) tick();
      tick();
      idle();
      for (int k = 0; k < 15; k++) begin push1(); tick(); end
      chk(!full, "R9 ignored release", int'(full), 0);
      push1(); tick();
      idle();
      chk(full, "R9 full after depth", int'(full), 1);

      // random traffic from a clean reset
      rst_n = 0; tick(); tick(); rst_n = 1;
      for (int c = 0; c < 4000; c++) begin
         int inflight, hp;
         bit blocked;
         idle();
         inflight = n_alloc - n_ret;
         hp = n_ret % D;
         if ($urandom % 2) push1();
         if (inflight < D - 1 && ($urandom % 3 != 0)) dec_take = 1;
         if (inflight > 0 && ($urandom % 2)) begin
            rd_req = 1;
            rd_tag = TW'((n_ret + int'($urandom % inflight)) % D);
         end
         blocked = rd_req && (int'(rd_tag) == hp);
         for (int i = 0; i < P; i++) if (pv[i] && pt[i] == hp) blocked = 1;
         if (inflight > 0 && m_v[hp] && !blocked && ($urandom % 3 == 0)) ret_req = 1;
         tick();
      end
      idle();
      tick();
      finish_run();
   end

endmodule